// File: doc/BRIEF.md
# Source-Routing Frame Match Engine

This block sits beside the receive path of a token-ring bridge adapter and decides, while a frame is still arriving, whether the adapter should copy that frame for forwarding to the neighbouring ring. It reads the received bytes in order and checks the routing indicator in the source address. It then decodes the routing-control word. Finally it walks the list of route designators and looks for the hop that crosses this bridge.

The host programs six values with a single load strobe: the adapter's own ring and bridge numbers, the partner adapter's ring and bridge numbers, the split width K between ring number and bridge number, and an enable for single-route broadcasts. If any of these values is invalid, the block stays disabled. The result is shown on two lines, copy and reject, plus a drive-enable flag that stands in for a tri-stated pair. A registered done flag rises when the verdict is taken.

Top module: `srt_match_engine`

## Requirements
- R1: While `rst_n` is low, and after reset until a valid load, `out_en`, `xmatch`, `xfail` and `done` are all low and received bytes have no effect.
- R2: A `cfg_load` pulse clears any frame in progress and any verdict. On the next cycle `out_en` equals the validity of the supplied values. The values are valid when all of these hold: K is 1 to 15; both bridge numbers fit in K bits; both ring numbers fit in 16−K bits; both ring numbers are nonzero; the two ring numbers differ. Invalid values are not stored.
- R3: `xmatch` and `xfail` are never high together. `done` is high exactly when one of them is high. The verdict holds until the next `sof` with a byte or the next load. A `sof` byte returns both lines low, which is the armed state.
- R4: Byte 0 arrives with `sof`. Bytes 2–7 are the destination address and bytes 8–13 the source address. If bit 7 of byte 8 is 0, `xfail` rises in the cycle after byte 8.
- R5: Routing control is bytes 14 and 15. Byte 14 bits 7:5 are the broadcast type and bits 4:0 the field length. The frame fails in the cycle after byte 14 if the length is odd, 0, 4 or above 30, or if the length is 2 and byte 14 bit 7 is 0. A length of 30, which holds 14 designators, is accepted.
- R6: When byte 14 bit 7 is 0 and byte 15 bit 7 is 0, the frame is copied when some designator equals the own ring and own bridge and the next designator's ring field equals the partner ring. Otherwise it fails. The verdict is taken after the last designator byte, at byte index 13 + length.
- R7: When byte 14 bit 7 is 0 and byte 15 bit 7 is 1, the frame is copied when some designator equals the partner ring and partner bridge and the designator after it carries the own ring. Otherwise it fails.
- R8: When byte 14 bits 7:6 are 10, the frame is copied exactly when the ring field of the last designator equals the own ring. With length 2 it is copied in the cycle after byte 15.
- R9: When byte 14 bits 7:6 are 11, the frame fails in the cycle after byte 14 if single-route forwarding was loaded as disabled. If it was loaded as enabled, the R8 rule applies.
- R10: Byte 14 bit 5 and byte 15 bits 6:0 do not change the verdict.
- R11: If `frm_end` arrives before the verdict, `xfail` rises in the cycle after it. If `frm_end` arrives after the verdict, it changes nothing.
- R12: A ring number that appears more than once in the designator list does not stop a match.
- R13: Each designator is read as a 16-bit word, with byte 16 + 2n as its high byte. The ring field is the upper 16−K bits and the bridge field the lower K bits, using the loaded K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the bridge values |
| cfg_own_ring | input | 16 | Own ring number |
| cfg_own_brg | input | 16 | Own bridge number |
| cfg_peer_ring | input | 16 | Partner ring number |
| cfg_peer_brg | input | 16 | Partner bridge number |
| cfg_k | input | 4 | Bridge field width K |
| cfg_sr_en | input | 1 | Single-route broadcast forwarding enable |
| sof | input | 1 | Marks the first byte of a frame (taken with byte_vld) |
| byte_vld | input | 1 | Byte qualifier |
| byte_dat | input | 8 | Received byte |
| frm_end | input | 1 | Frame has ended |
| out_en | output | 1 | Verdict lines driven (low models tri-state) |
| xmatch | output | 1 | Copy the frame |
| xfail | output | 1 | Do not copy the frame |
| done | output | 1 | Verdict registered for this frame |

## Verification
The assertions check the encoding rules on every cycle: the two verdict lines are mutually exclusive, `done` agrees with them, nothing is driven while disabled, a verdict holds steady until a new frame or load, and a load with K of zero disables the block. Whether a given routing field should be copied can only be shown by the bench's frames, which are compared against a behavioural reference. These frames cover both scan directions, both broadcast kinds, the length limits, ignored bits, truncation, repeated rings and a second split width.

// File: rtl/srt_match_engine.sv
module srt_match_engine #(
  parameter int MAX_RI = 30,
  parameter int IDX_W  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic [15:0] cfg_own_ring,
  input  logic [15:0] cfg_own_brg,
  input  logic [15:0] cfg_peer_ring,
  input  logic [15:0] cfg_peer_brg,
  input  logic [3:0]  cfg_k,
  input  logic        cfg_sr_en,
  input  logic        sof,
  input  logic        byte_vld,
  input  logic [7:0]  byte_dat,
  input  logic        frm_end,
  output logic        out_en,
  output logic        xmatch,
  output logic        xfail,
  output logic        done
);
  localparam int SA_AT = 8;
  localparam int RC_AT = 14;
  localparam int RD_AT = 16;
  localparam logic [IDX_W-1:0] FIN_BASE = IDX_W'(RC_AT - 1);

  logic en, sr_en_q;
  logic [15:0] own_des, peer_des, own_ring_sh, peer_ring_sh, ring_mask;
  logic busy, done_q, m_q, f_q;
  logic [IDX_W-1:0] cnt;
  logic bc_q, dir_q, have_prev, hit_q;
  logic [4:0] len_q;
  logic [7:0] hi_q;
  logic [15:0] prev_q;

  logic [4:0] rk;
  logic cfg_ok;
  assign rk = 5'd16 - {1'b0, cfg_k};
  assign cfg_ok = (cfg_k != 4'd0)
               && ((cfg_own_brg  >> cfg_k) == 16'd0)
               && ((cfg_peer_brg >> cfg_k) == 16'd0)
               && ((cfg_own_ring  >> rk) == 16'd0)
               && ((cfg_peer_ring >> rk) == 16'd0)
               && (cfg_own_ring != 16'd0) && (cfg_peer_ring != 16'd0)
               && (cfg_own_ring != cfg_peer_ring);

  logic take;
  logic [IDX_W-1:0] idx;
  logic [15:0] des;
  logic [4:0] rc_len;
  logic rc_bad, des_end, fin, ring_own_now, ring_peer_now, pair_hit;

  assign take   = en && byte_vld && (sof || busy);
  assign idx    = sof ? '0 : cnt;
  assign des    = {hi_q, byte_dat};
  assign rc_len = byte_dat[4:0];
  assign rc_bad = rc_len[0] || (rc_len == 5'd0) || (rc_len == 5'd4)
               || (32'(rc_len) > MAX_RI)
               || (!byte_dat[7] && rc_len == 5'd2)
               || (byte_dat[7:6] == 2'b11 && !sr_en_q);
  assign des_end = (idx >= IDX_W'(RD_AT)) && idx[0];
  assign fin     = des_end && (idx == FIN_BASE + IDX_W'(len_q));
  assign ring_own_now  = (des & ring_mask) == own_ring_sh;
  assign ring_peer_now = (des & ring_mask) == peer_ring_sh;
  assign pair_hit = have_prev && (dir_q ? (prev_q == peer_des && ring_own_now)
                                        : (prev_q == own_des  && ring_peer_now));

  logic dec, dm;
  always_comb begin
    dec = 1'b0;
    dm  = 1'b0;
    if (idx == IDX_W'(SA_AT) && !byte_dat[7]) begin
      dec = 1'b1;
    end else if (idx == IDX_W'(RC_AT) && rc_bad) begin
      dec = 1'b1;
    end else if (idx == IDX_W'(RC_AT + 1) && len_q == 5'd2) begin
      dec = 1'b1;
      dm  = 1'b1;
    end else if (fin) begin
      dec = 1'b1;
      dm  = bc_q ? ring_own_now : (hit_q || pair_hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; sr_en_q <= 1'b0;
      own_des <= '0; peer_des <= '0; own_ring_sh <= '0; peer_ring_sh <= '0; ring_mask <= '0;
      busy <= 1'b0; done_q <= 1'b0; m_q <= 1'b0; f_q <= 1'b0;
      cnt <= '0; bc_q <= 1'b0; dir_q <= 1'b0; have_prev <= 1'b0; hit_q <= 1'b0;
      len_q <= '0; hi_q <= '0; prev_q <= '0;
    end else if (cfg_load) begin
      en <= cfg_ok;
      busy <= 1'b0; done_q <= 1'b0; m_q <= 1'b0; f_q <= 1'b0;
      if (cfg_ok) begin
        sr_en_q      <= cfg_sr_en;
        own_des      <= (cfg_own_ring << cfg_k) | cfg_own_brg;
        peer_des     <= (cfg_peer_ring << cfg_k) | cfg_peer_brg;
        own_ring_sh  <= cfg_own_ring << cfg_k;
        peer_ring_sh <= cfg_peer_ring << cfg_k;
        ring_mask    <= 16'hFFFF << cfg_k;
      end
    end else if (take) begin
      cnt    <= idx + 1'b1;
      busy   <= !dec && !frm_end;
      done_q <= dec || frm_end;
      m_q    <= dec && dm;
      f_q    <= dec ? !dm : frm_end;
      if (idx == IDX_W'(RC_AT)) begin
        bc_q  <= byte_dat[7];
        len_q <= rc_len;
      end
      if (idx == IDX_W'(RC_AT + 1)) dir_q <= byte_dat[7];
      if (idx >= IDX_W'(RD_AT) && !idx[0]) hi_q <= byte_dat;
      if (des_end) begin
        prev_q    <= des;
        have_prev <= 1'b1;
        hit_q     <= hit_q || pair_hit;
      end else if (idx < IDX_W'(RD_AT)) begin
        have_prev <= 1'b0;
        hit_q     <= 1'b0;
      end
    end else if (frm_end && busy) begin
      busy <= 1'b0; done_q <= 1'b1; f_q <= 1'b1; m_q <= 1'b0;
    end
  end

  assign out_en = en;
  assign xmatch = m_q;
  assign xfail  = f_q;
  assign done   = done_q;
endmodule

module srt_match_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_load,
  input logic [3:0] cfg_k,
  input logic       sof,
  input logic       byte_vld,
  input logic       frm_end,
  input logic       out_en,
  input logic       xmatch,
  input logic       xfail,
  input logic       done
);
  // R3
  excl_lines_chk: assert property (@(posedge clk) disable iff (!rst_n) !(xmatch && xfail));
  // R1
  quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!xmatch && !xfail && !done));
  // R3
  done_agree_chk: assert property (@(posedge clk) disable iff (!rst_n) done == (xmatch || xfail));
  // R3
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(sof && byte_vld) && !cfg_load) |=> ($stable(xmatch) && $stable(xfail)));
  // R3
  new_frame_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && sof && byte_vld && !frm_end && !cfg_load) |=> !done);
  // R2
  zero_k_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && cfg_k == 4'd0) |=> !out_en);
endmodule

bind srt_match_engine srt_match_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_k(cfg_k), .sof(sof),
  .byte_vld(byte_vld), .frm_end(frm_end), .out_en(out_en), .xmatch(xmatch),
  .xfail(xfail), .done(done)
);

// File: tb/srt_match_engine_bench.sv
`timescale 1ns/1ps
module srt_match_engine_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_load, cfg_sr_en, sof, byte_vld, frm_end;
  logic [15:0] cfg_own_ring, cfg_own_brg, cfg_peer_ring, cfg_peer_brg;
  logic [3:0] cfg_k;
  logic [7:0] byte_dat;
  logic out_en, xmatch, xfail, done;

  srt_match_engine u_srt_match_engine (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_own_ring(cfg_own_ring), .cfg_own_brg(cfg_own_brg),
    .cfg_peer_ring(cfg_peer_ring), .cfg_peer_brg(cfg_peer_brg),
    .cfg_k(cfg_k), .cfg_sr_en(cfg_sr_en), .sof(sof), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .frm_end(frm_end), .out_en(out_en), .xmatch(xmatch),
    .xfail(xfail), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit e_en, e_m, e_f, e_d;
  int m_or, m_ob, m_pr, m_pb, m_k;
  bit m_sr;
  byte unsigned fq[$];
  int dq[$];

  task automatic chk(string tag);
    n_chk++;
    if (out_en !== e_en || xmatch !== e_m || xfail !== e_f || done !== e_d) begin
      n_bad++;
      $display("FAIL %s: en,match,fail,done got %b%b%b%b expected %b%b%b%b",
               tag, out_en, xmatch, xfail, done, e_en, e_m, e_f, e_d);
    end
  endtask

  function automatic bit cfg_valid(int o_r, int o_b, int p_r, int p_b, int k);
    if (k < 1 || k > 15) return 0;
    if (o_b >= (1 << k) || p_b >= (1 << k)) return 0;
    if (o_r >= (1 << (16 - k)) || p_r >= (1 << (16 - k))) return 0;
    if (o_r == 0 || p_r == 0 || o_r == p_r) return 0;
    return 1;
  endfunction

  task automatic load(int o_r, int o_b, int p_r, int p_b, int k, bit sr, string tag);
    bit v;
    cfg_own_ring = 16'(o_r); cfg_own_brg = 16'(o_b);
    cfg_peer_ring = 16'(p_r); cfg_peer_brg = 16'(p_b);
    cfg_k = 4'(k); cfg_sr_en = sr; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    v = cfg_valid(o_r, o_b, p_r, p_b, k);
    e_en = v; e_m = 0; e_f = 0; e_d = 0;
    if (v) begin
      m_or = o_r; m_ob = o_b; m_pr = p_r; m_pb = p_b; m_k = k; m_sr = sr;
    end
    chk(tag);
  endtask

  function automatic void mk(bit ri, int bc, int len, int rc2);
    fq.delete();
    fq.push_back(8'h10); fq.push_back(8'h40);
    for (int i = 0; i < 6; i++) fq.push_back(8'(8'hC0 + i));
    fq.push_back(ri ? 8'h85 : 8'h05);
    for (int i = 0; i < 5; i++) fq.push_back(8'(8'h31 + i));
    fq.push_back(8'((bc << 5) | len));
    fq.push_back(8'(rc2));
    foreach (dq[i]) begin
      fq.push_back(8'(dq[i] >> 8));
      fq.push_back(8'(dq[i]));
    end
    for (int i = 0; i < 4; i++) fq.push_back(8'(8'hA0 + i));
  endfunction

  function automatic void ref_eval(output int at, output bit res);
    int bc, len, dir, n;
    int d[$];
    res = 0;
    at = 8;
    if (fq[8][7] == 1'b0) return;
    bc = int'(fq[14]) >> 5; len = int'(fq[14]) & 31; dir = int'(fq[15]) >> 7;
    at = 14;
    if ((len % 2) != 0 || len == 0 || len == 4 || len > 30) return;
    if (bc < 4 && len == 2) return;
    if (bc >= 6 && !m_sr) return;
    n = (len - 2) / 2;
    if (n == 0) begin at = 15; res = 1; return; end
    at = 13 + len;
    for (int i = 0; i < n; i++) d.push_back((int'(fq[16 + 2*i]) << 8) | int'(fq[17 + 2*i]));
    if (bc >= 4) begin
      res = ((d[n-1] >> m_k) == m_or);
    end else if (dir == 0) begin
      for (int i = 0; i + 1 < n; i++)
        if (d[i] == ((m_or << m_k) | m_ob) && (d[i+1] >> m_k) == m_pr) res = 1;
    end else begin
      for (int i = n - 1; i >= 1; i--)
        if ((d[i] >> m_k) == m_or && d[i-1] == ((m_pr << m_k) | m_pb)) res = 1;
    end
  endfunction

  task automatic send(int cut, bit with_end, string tag);
    int at, n;
    bit res;
    ref_eval(at, res);
    n = (cut < 0) ? fq.size() : cut;
    for (int i = 0; i < n; i++) begin
      sof = (i == 0); byte_vld = 1'b1; byte_dat = fq[i];
      frm_end = with_end && (i == n - 1);
      @(negedge clk);
      if (e_en) begin
        if (i == 0) begin e_d = 0; e_m = 0; e_f = 0; end
        if (!e_d) begin
          if (i == at) begin e_d = 1; e_m = res; e_f = !res; end
          else if (frm_end) begin e_d = 1; e_f = 1; end
        end
      end
      chk(tag);
    end
    sof = 0; byte_vld = 0; frm_end = 0; byte_dat = 8'h00;
    @(negedge clk);
    chk(tag);
  endtask

  initial begin
    rst_n = 0; cfg_load = 0; cfg_sr_en = 0; sof = 0; byte_vld = 0; frm_end = 0;
    cfg_own_ring = 0; cfg_own_brg = 0; cfg_peer_ring = 0; cfg_peer_brg = 0;
    cfg_k = 0; byte_dat = 0;
    e_en = 0; e_m = 0; e_f = 0; e_d = 0;
    m_or = 1; m_ob = 3; m_pr = 2; m_pb = 5; m_k = 4; m_sr = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset");
    dq = '{16'h0013, 16'h0027};
    mk(1, 0, 6, 0);
    send(-1, 1, "R1 unconfigured frame ignored");

    load(1, 3, 2, 5, 0, 0, "R2 K zero rejected");
    load(1, 16, 2, 5, 4, 0, "R2 bridge too wide rejected");
    load(3, 3, 3, 5, 4, 0, "R2 equal rings rejected");
    load(1, 3, 2, 5, 4, 0, "R2 valid load arms");

    dq = '{16'h0013, 16'h0027};
    mk(0, 0, 6, 0);
    send(-1, 0, "R4 no routing indicator");

    dq = '{16'h0051, 16'h0013, 16'h0027, 16'h0090};
    mk(1, 0, 10, 0);
    send(-1, 0, "R6 forward pair matches");
    dq = '{16'h0051, 16'h0014, 16'h0027, 16'h0090};
    mk(1, 0, 10, 0);
    send(-1, 0, "R6 wrong own bridge");
    dq = '{16'h0027, 16'h0013, 16'h0090};
    mk(1, 0, 8, 0);
    send(-1, 0, "R6 reversed pair");

    dq = '{16'h0030, 16'h0025, 16'h001A};
    mk(1, 0, 8, 8'h80);
    send(-1, 0, "R7 reverse pair matches");
    dq = '{16'h0013, 16'h0027};
    mk(1, 0, 6, 8'h80);
    send(-1, 0, "R7 forward layout rejected");

    dq = '{16'h0013, 16'h0027};
    mk(1, 0, 7, 0);  send(-1, 0, "R5 odd length");
    mk(1, 0, 4, 0);  send(-1, 0, "R5 length four");
    mk(1, 0, 0, 0);  send(-1, 0, "R5 length zero");
    mk(1, 0, 31, 0); send(-1, 0, "R5 length above max");
    dq = '{};
    mk(1, 0, 2, 0);  send(-1, 0, "R5 length two specific route");
    dq = '{};
    for (int i = 0; i < 12; i++) dq.push_back(16'h0040 + i);
    dq.push_back(16'h0013); dq.push_back(16'h0027);
    mk(1, 0, 30, 0); send(-1, 0, "R5 maximum length matches");

    dq = '{16'h0072, 16'h0010};
    mk(1, 4, 6, 0);  send(-1, 0, "R8 all-routes final ring own");
    dq = '{16'h0012, 16'h0070};
    mk(1, 4, 6, 0);  send(-1, 0, "R8 all-routes final ring other");
    dq = '{};
    mk(1, 4, 2, 0);  send(-1, 0, "R8 all-routes fresh length two");

    dq = '{16'h0072, 16'h0010};
    mk(1, 6, 6, 0);  send(-1, 0, "R9 single-route disabled");
    load(1, 3, 2, 5, 4, 1, "R9 enable single-route");
    mk(1, 6, 6, 0);  send(-1, 0, "R9 single-route enabled");

    mk(1, 5, 6, 8'h7F); send(-1, 0, "R10 indicator bit two ignored");
    dq = '{16'h0013, 16'h0027};
    mk(1, 3, 6, 8'h7F); send(-1, 0, "R10 reserved bits ignored");

    dq = '{16'h0051, 16'h0013, 16'h0027};
    mk(1, 0, 8, 0);
    send(18, 1, "R11 early end fails");
    send(-1, 1, "R11 end after verdict ignored");

    dq = '{16'h0010, 16'h0027, 16'h0013, 16'h0020};
    mk(1, 0, 10, 0);
    send(-1, 0, "R12 repeated ring still matches");

    load(16'h12, 16'h34, 16'h56, 16'h78, 8, 0, "R13 load K eight");
    dq = '{16'h1234, 16'h5600};
    mk(1, 0, 6, 0);  send(-1, 0, "R13 wide split matches");
    dq = '{16'h1234, 16'h5700};
    mk(1, 0, 6, 0);  send(-1, 0, "R13 wide split ring mismatch");

    dq = '{16'h1234, 16'h5600, 16'h0001};
    mk(1, 0, 8, 0);
    send(12, 0, "R2 frame in progress");
    load(16'h12, 16'h34, 16'h56, 16'h78, 8, 0, "R2 load clears frame");
    send(-1, 0, "R3 fresh frame after load");

    rst_n = 0;
    e_en = 0; e_m = 0; e_f = 0; e_d = 0;
    @(negedge clk);
    chk("R1 reset mid-operation");
    rst_n = 1;
    @(negedge clk);
    chk("R1 stays disabled after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule